// File: doc/BRIEF.md
# Raster-Synchronised Register-Write Coprocessor

This block steps through a looping list of 16-bit instructions in time with the video beam. Its job is to drop byte values into a 128-entry register space at chosen screen positions, so that a host processor does not have to time those writes itself. The raster generator supplies the current line, the horizontal dot count, a high-resolution flag and a pulse at the first dot of each frame. A program memory with one cycle of synchronous read latency returns the instruction word at the address that the block presents. The block's output is a single-cycle register write port.

The instruction set has three members. An idle word burns one dot. A transfer word writes one byte to one register. A sync word holds execution until the beam reaches a given position. A 2-bit run code with a write strobe starts, stops, resumes and re-arms the program. The code only acts when it differs from the code written before it. The address presented to memory is the address of the instruction that will execute in the following cycle. Because of this, idle and sync words keep a one-instruction-per-dot cadence.

Top module: `rast_copro`

## Requirements
- R1: After reset the block is stopped, the program counter is 0 (pc_o = 0) and wr_en_o is low.
- R2: The word 0x0000 is an idle instruction: it completes in one dot clock and makes no register write.
- R3: A nonzero word with bit 15 clear is a transfer: bits 14..8 give the register address and bits 7..0 the data. It takes two dot clocks, and wr_en_o is high for exactly the second of them, with wr_addr_o and wr_data_o set to those fields.
- R4: A word with bit 15 set is a sync: its line field is bits 8..0 and must equal line_i exactly. A sync on a line that has already gone by therefore holds until that line comes round in a later frame.
- R5: The horizontal field of a sync is bits 14..9. Once the line matches, the sync completes in the first cycle in which hdot_i + 3 (hires_i = 0) or hdot_i + 2 (hires_i = 1) is at least field × 16.
- R6: The program counter is 10 bits wide. It steps by one after each completed instruction and wraps from 1023 to 0.
- R7: Run code 0 stops execution and keeps the program counter. While the block is stopped, no write is made.
- R8: Run code 1 clears the program counter and runs, which also restarts a program that is already running.
- R9: Run code 2 runs from the current program counter and leaves frame restart disarmed.
- R10: Run code 3 clears the program counter and runs. While this code is in force, every frame_i pulse (first dot of line 0) returns the program counter to 0.
- R11: A run code written while it equals the last accepted code has no effect on execution.
- R12: A sync on a position that never occurs, such as 0xFFFF, holds the program counter indefinitely. Only a new run code or a frame restart under code 3 moves execution on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 9 | Current raster line |
| hdot_i | input | 10 | Current horizontal dot count within the line |
| hires_i | input | 1 | High-resolution mode (selects 2-dot early completion instead of 3) |
| frame_i | input | 1 | Pulse at line 0, dot 0 |
| ins_i | input | 16 | Instruction word read from pc_o in the previous cycle |
| mode_i | input | 2 | Run code |
| mode_we_i | input | 1 | Run code write strobe |
| pc_o | output | 10 | Program memory word address (next instruction) |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 7 | Register write address |
| wr_data_o | output | 8 | Register write data |

## Verification
The beam-position engine is driven with a free-running raster model and several programs, and the scoreboard checks the position of each write. One program chains a mid-line sync, an idle between two transfers, a sync on a later line at dot 0 and a sync on a line already passed. These tell the exact-line rule apart from the greater-or-equal horizontal rule, and show the 3-dot early completion and the one-dot idle. A second program runs in high-resolution mode under frame restart and is rewritten with the same code mid-frame, which separates the 2-dot adjustment, the per-frame restart and the change-only code rule. Further patterns resume from a held position and walk a full 1024-word list across the wrap, which tells resume apart from clear and exposes the program counter width.

// File: rtl/copro_pkg.sv
package copro_pkg;

   // run codes as written on mode_i
   typedef enum logic [1:0] {
      CM_HALT       = 2'd0,
      CM_ZERO_GO    = 2'd1,
      CM_RESUME     = 2'd2,
      CM_FRAME_LOOP = 2'd3
   } cmode_e;

   // decoded instruction class
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_XFER = 2'd1,
      OP_SYNC = 2'd2
   } op_e;

endpackage

// File: rtl/copro_decode.sv
module copro_decode
   import copro_pkg::*;
#(
   parameter int INS_W  = 16,
   parameter int REG_AW = 7,
   parameter int DATA_W = 8,
   parameter int LINE_W = 9,
   parameter int HF_W   = 6
) (
   input  logic [INS_W-1:0]  ins_i,
   output op_e               op_o,
   output logic [REG_AW-1:0] reg_o,
   output logic [DATA_W-1:0] dat_o,
   output logic [HF_W-1:0]   hf_o,
   output logic [LINE_W-1:0] vf_o
);

   always_comb begin
      if (ins_i[INS_W-1])
         op_o = OP_SYNC;
      else if (ins_i == '0)
         op_o = OP_IDLE;
      else
         op_o = OP_XFER;
   end

   assign reg_o = ins_i[REG_AW+DATA_W-1:DATA_W];
   assign dat_o = ins_i[DATA_W-1:0];
   assign hf_o  = ins_i[LINE_W+HF_W-1:LINE_W];
   assign vf_o  = ins_i[LINE_W-1:0];

endmodule

// File: rtl/copro_beam_cmp.sv
module copro_beam_cmp #(
   parameter int LINE_W   = 9,
   parameter int HDOT_W   = 10,
   parameter int HF_W     = 6,
   parameter int HSTEP_LG = 4,
   parameter int ADJ_STD  = 3,
   parameter int ADJ_HI   = 2,
   parameter bit EARLY    = 1'b1
) (
   input  logic [LINE_W-1:0] line_i,
   input  logic [HDOT_W-1:0] hdot_i,
   input  logic              hires_i,
   input  logic [LINE_W-1:0] vf_i,
   input  logic [HF_W-1:0]   hf_i,
   output logic              hit_o
);

   localparam int TGT_W = HF_W + HSTEP_LG;
   localparam int CMP_W = ((HDOT_W > TGT_W) ? HDOT_W : TGT_W) + 1;

   logic [CMP_W-1:0] adj_w;
   logic [CMP_W-1:0] lhs_w;
   logic [CMP_W-1:0] tgt_w;

   generate
      if (EARLY) begin : g_early
         assign adj_w = hires_i ? CMP_W'(ADJ_HI) : CMP_W'(ADJ_STD);
      end else begin : g_exact
         assign adj_w = '0;
      end
   endgenerate

   assign lhs_w = CMP_W'(hdot_i) + adj_w;
   assign tgt_w = CMP_W'({hf_i, {HSTEP_LG{1'b0}}});
   assign hit_o = (line_i == vf_i) && (lhs_w >= tgt_w);

endmodule

// File: rtl/copro_modectl.sv
module copro_modectl
   import copro_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       mode_we_i,
   output logic       chg_o,
   output logic       clr_pc_o,
   output logic       run_o,
   output logic       frm_o,
   output logic [1:0] last_o
);

   cmode_e last_q;
   cmode_e req_w;
   logic   run_q;
   logic   frm_q;

   assign req_w    = cmode_e'(mode_i);
   assign chg_o    = mode_we_i && (req_w != last_q);
   assign clr_pc_o = chg_o && ((req_w == CM_ZERO_GO) || (req_w == CM_FRAME_LOOP));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= CM_HALT;
         run_q  <= 1'b0;
         frm_q  <= 1'b0;
      end else if (chg_o) begin
         last_q <= req_w;
         run_q  <= (req_w != CM_HALT);
         frm_q  <= (req_w == CM_FRAME_LOOP);
      end
   end

   assign run_o  = run_q;
   assign frm_o  = frm_q;
   assign last_o = last_q;

endmodule

// File: rtl/rast_copro.sv
module rast_copro
   import copro_pkg::*;
#(
   parameter int INS_W    = 16,
   parameter int PC_W     = 10,
   parameter int LINE_W   = 9,
   parameter int HDOT_W   = 10,
   parameter int REG_AW   = 7,
   parameter int DATA_W   = 8,
   parameter int HSTEP_LG = 4,
   parameter int ADJ_STD  = 3,
   parameter int ADJ_HI   = 2,
   parameter bit EARLY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line_i,
   input  logic [HDOT_W-1:0] hdot_i,
   input  logic              hires_i,
   input  logic              frame_i,
   input  logic [INS_W-1:0]  ins_i,
   input  logic [1:0]        mode_i,
   input  logic              mode_we_i,
   output logic [PC_W-1:0]   pc_o,
   output logic              wr_en_o,
   output logic [REG_AW-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o
);

   localparam int HF_W = INS_W - 1 - LINE_W;

   generate
      if (INS_W != 1 + REG_AW + DATA_W) begin : g_bad_xfer
         $error("transfer fields do not fill the instruction word");
      end
      if (HF_W < 1) begin : g_bad_sync
         $error("no room for a horizontal field");
      end
      if (PC_W < 1 || HDOT_W < 1) begin : g_bad_w
         $error("counter widths must be positive");
      end
   endgenerate

   op_e               op_w;
   logic [REG_AW-1:0] reg_w;
   logic [DATA_W-1:0] dat_w;
   logic [HF_W-1:0]   hf_w;
   logic [LINE_W-1:0] vf_w;
   logic              hit_w;
   logic              chg_w;
   logic              clr_w;
   logic              run_w;
   logic              frm_w;
   logic [1:0]        last_w;

   logic [PC_W-1:0]   pc_q;
   logic [PC_W-1:0]   pc_nxt;
   logic              mv_q;
   logic              mv_nxt;
   logic              go_xfer;
   logic              wen_q;
   logic [REG_AW-1:0] wa_q;
   logic [DATA_W-1:0] wd_q;

   copro_decode #(
      .INS_W(INS_W), .REG_AW(REG_AW), .DATA_W(DATA_W),
      .LINE_W(LINE_W), .HF_W(HF_W)
   ) u_dec (
      .ins_i(ins_i), .op_o(op_w), .reg_o(reg_w), .dat_o(dat_w),
      .hf_o(hf_w), .vf_o(vf_w)
   );

   copro_beam_cmp #(
      .LINE_W(LINE_W), .HDOT_W(HDOT_W), .HF_W(HF_W), .HSTEP_LG(HSTEP_LG),
      .ADJ_STD(ADJ_STD), .ADJ_HI(ADJ_HI), .EARLY(EARLY)
   ) u_cmp (
      .line_i(line_i), .hdot_i(hdot_i), .hires_i(hires_i),
      .vf_i(vf_w), .hf_i(hf_w), .hit_o(hit_w)
   );

   copro_modectl u_mode (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_we_i(mode_we_i),
      .chg_o(chg_w), .clr_pc_o(clr_w), .run_o(run_w), .frm_o(frm_w),
      .last_o(last_w)
   );

   // sequencer: run-code change, then frame restart, then execution
   always_comb begin
      pc_nxt  = pc_q;
      mv_nxt  = mv_q;
      go_xfer = 1'b0;
      if (chg_w) begin
         mv_nxt = 1'b0;
         if (clr_w)
            pc_nxt = '0;
         else if (mv_q)
            pc_nxt = pc_q + 1'b1;
      end else if (run_w && frm_w && frame_i) begin
         pc_nxt = '0;
         mv_nxt = 1'b0;
      end else if (run_w) begin
         if (mv_q) begin
            mv_nxt = 1'b0;
            pc_nxt = pc_q + 1'b1;
         end else begin
            unique case (op_w)
               OP_IDLE: pc_nxt = pc_q + 1'b1;
               OP_XFER: begin
                  mv_nxt  = 1'b1;
                  go_xfer = 1'b1;
               end
               OP_SYNC: if (hit_w) pc_nxt = pc_q + 1'b1;
               default: pc_nxt = pc_q;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= '0;
         mv_q  <= 1'b0;
         wen_q <= 1'b0;
         wa_q  <= '0;
         wd_q  <= '0;
      end else begin
         pc_q  <= pc_nxt;
         mv_q  <= mv_nxt;
         wen_q <= go_xfer;
         if (go_xfer) begin
            wa_q <= reg_w;
            wd_q <= dat_w;
         end
      end
   end

   assign pc_o      = pc_nxt;
   assign wr_en_o   = wen_q;
   assign wr_addr_o = wa_q;
   assign wr_data_o = wd_q;

endmodule

// File: rtl/copro_chk.sv
module copro_chk #(
   parameter int INS_W  = 16,
   parameter int PC_W   = 10,
   parameter int LINE_W = 9,
   parameter int REG_AW = 7,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LINE_W-1:0] line_i,
   input logic              frame_i,
   input logic [INS_W-1:0]  ins_i,
   input logic [1:0]        mode_i,
   input logic              mode_we_i,
   input logic              wr_en_o,
   input logic [REG_AW-1:0] wr_addr_o,
   input logic [DATA_W-1:0] wr_data_o,
   input logic [PC_W-1:0]   pc_q,
   input logic              mv_q,
   input logic              run_w,
   input logic              frm_w,
   input logic              chg_w,
   input logic [1:0]        last_w
);

   logic quiet_w;
   assign quiet_w = !chg_w && !(frm_w && frame_i);

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pc_q == '0 && !wr_en_o && !run_w));

   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   // R3
   strobe_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_addr_o == $past(ins_i[REG_AW+DATA_W-1:DATA_W]) &&
                   wr_data_o == $past(ins_i[DATA_W-1:0])));

   // R7
   stop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_w |=> !wr_en_o);

   // R6
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + 1'b1 || pc_q == '0));

   // R2
   idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_w && !mv_q && ins_i == '0 && quiet_w) |=> (pc_q == $past(pc_q) + 1'b1));

   // R4
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_w && !mv_q && ins_i[INS_W-1] && line_i != ins_i[LINE_W-1:0] && quiet_w)
      |=> (pc_q == $past(pc_q)));

   // R11
   same_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_we_i && mode_i == last_w) |=> (run_w == $past(run_w) && frm_w == $past(frm_w)));

endmodule

bind rast_copro copro_chk #(
   .INS_W(INS_W), .PC_W(PC_W), .LINE_W(LINE_W), .REG_AW(REG_AW), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line_i(line_i), .frame_i(frame_i), .ins_i(ins_i),
   .mode_i(mode_i), .mode_we_i(mode_we_i), .wr_en_o(wr_en_o),
   .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .pc_q(pc_q), .mv_q(mv_q),
   .run_w(run_w), .frm_w(frm_w), .chg_w(chg_w), .last_w(last_w)
);

// File: tb/sim_rast_copro.sv
module sim_rast_copro;

   localparam int HTOT  = 200;
   localparam int NL    = 12;
   localparam int FRAME = HTOT * NL;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  line_i = '0;
   logic [9:0]  hdot_i = '0;
   logic        hires_i = 1'b0;
   logic        frame_i;
   logic [15:0] ins_i = '0;
   logic [1:0]  mode_i = '0;
   logic        mode_we_i = 1'b0;
   logic [9:0]  pc_o;
   logic        wr_en_o;
   logic [6:0]  wr_addr_o;
   logic [7:0]  wr_data_o;

   logic [15:0] mem [1024];

   typedef struct {
      int         pos;
      logic [6:0] a;
      logic [7:0] d;
      string      req;
   } exp_t;
   exp_t sb[$];

   int n_chk = 0;
   int n_bad = 0;
   int n_wr  = 0;
   int issue_pos = 0;

   always #5 clk = ~clk;

   rast_copro u0 (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .hdot_i(hdot_i),
      .hires_i(hires_i), .frame_i(frame_i), .ins_i(ins_i), .mode_i(mode_i),
      .mode_we_i(mode_we_i), .pc_o(pc_o), .wr_en_o(wr_en_o),
      .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
   );

   // raster model and synchronous program memory
   assign frame_i = (line_i == 9'd0) && (hdot_i == 10'd0);

   always @(posedge clk) begin
      if (!rst_n) begin
         line_i <= '0;
         hdot_i <= '0;
      end else if (hdot_i == 10'(HTOT - 1)) begin
         hdot_i <= '0;
         line_i <= (line_i == 9'(NL - 1)) ? 9'd0 : line_i + 9'd1;
      end else begin
         hdot_i <= hdot_i + 10'd1;
      end
   end

   always @(posedge clk) ins_i <= mem[pc_o];

   function automatic int pos_of(int l, int h);
      return l * HTOT + h;
   endfunction

   function automatic int padv(int p, int n);
      return (p + n) % FRAME;
   endfunction

   function automatic logic [15:0] sync_w(int h, int v);
      return {1'b1, 6'(h), 9'(v)};
   endfunction

   function automatic logic [15:0] xfer_w(int a, int d);
      return {1'b0, 7'(a), 8'(d)};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic push_w(input int p, input int a, input int d, input string req);
      exp_t e;
      e.pos = p; e.a = 7'(a); e.d = 8'(d); e.req = req;
      sb.push_back(e);
   endtask

   task automatic wait_pos(input int l, input int h);
      @(negedge clk);
      while (!(int'(line_i) == l && int'(hdot_i) == h)) @(negedge clk);
   endtask

   task automatic set_mode(input int m);
      issue_pos = pos_of(int'(line_i), int'(hdot_i));
      mode_i    = 2'(m);
      mode_we_i = 1'b1;
      @(negedge clk);
      mode_we_i = 1'b0;
   endtask

   // monitor: pop and compare every strobe against the scoreboard
   always @(negedge clk) begin
      if (rst_n && wr_en_o) begin
         n_wr++;
         if (sb.size() == 0) begin
            check(1'b0, "R3 R11 unexpected write", int'({wr_addr_o, wr_data_o}), 0);
         end else begin
            exp_t e;
            int   cur;
            e   = sb.pop_front();
            cur = pos_of(int'(line_i), int'(hdot_i));
            check(cur == e.pos, {e.req, " write position"}, cur, e.pos);
            check({wr_addr_o, wr_data_o} == {e.a, e.d}, {e.req, " R3 write fields"},
                  int'({wr_addr_o, wr_data_o}), int'({e.a, e.d}));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R12 watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int wr_mark;
      for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
      // program A: line/dot syncs, idle spacing, passed line
      mem[0] = sync_w(2, 3);
      mem[1] = xfer_w(8'h41, 8'hE0);
      mem[2] = 16'h0000;
      mem[3] = xfer_w(8'h12, 8'h34);
      mem[4] = sync_w(0, 5);
      mem[5] = xfer_w(8'h05, 8'h55);
      mem[6] = sync_w(3, 4);
      mem[7] = xfer_w(8'h06, 8'h66);
      mem[8] = 16'hFFFF;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(pc_o == 10'd0, "R1 pc after reset", int'(pc_o), 0);
      check(wr_en_o == 1'b0, "R1 strobe after reset", int'(wr_en_o), 0);
      repeat (20) @(negedge clk);
      check(pc_o == 10'd0 && n_wr == 0, "R1 stays stopped", int'(pc_o), 0);

      wait_pos(1, 0);
      set_mode(1);
      push_w(pos_of(3, 31), 8'h41, 8'hE0, "R5 R8");
      push_w(pos_of(3, 34), 8'h12, 8'h34, "R2");
      push_w(pos_of(5, 2),  8'h05, 8'h55, "R4");
      push_w(pos_of(4, 47), 8'h06, 8'h66, "R4 passed line");
      wait_pos(6, 0);
      wait_pos(5, 0);
      check(sb.size() == 0, "R4 all writes of list A seen", sb.size(), 0);
      check(pc_o == 10'd8, "R12 held on unreachable sync", int'(pc_o), 8);
      wait_pos(5, 0);
      check(pc_o == 10'd8, "R12 still held a frame later", int'(pc_o), 8);

      // program B: high-resolution sync under frame restart
      mem[0] = sync_w(1, 2);
      mem[1] = xfer_w(8'h20, 8'h01);
      mem[2] = 16'hFFFF;
      hires_i = 1'b1;
      wait_pos(1, 0);
      set_mode(3);
      push_w(pos_of(2, 16), 8'h20, 8'h01, "R5 R10 hires");
      push_w(pos_of(2, 16), 8'h20, 8'h01, "R10 restart");
      push_w(pos_of(2, 16), 8'h20, 8'h01, "R10 restart");
      wait_pos(2, 60);
      wr_mark = n_wr;
      set_mode(3);
      wait_pos(3, 0);
      check(n_wr == wr_mark, "R11 same code rewrite", n_wr, wr_mark);
      wait_pos(1, 0);
      wait_pos(3, 0);
      wait_pos(1, 0);
      wait_pos(5, 0);
      set_mode(0);
      check(sb.size() == 0, "R10 one write per frame", sb.size(), 0);
      check(pc_o == 10'd2, "R7 stop keeps pc", int'(pc_o), 2);
      wait_pos(5, 0);
      check(pc_o == 10'd2, "R7 no restart while stopped", int'(pc_o), 2);

      // resume from the held address
      hires_i = 1'b0;
      mem[2] = xfer_w(8'h30, 8'h77);
      mem[3] = sync_w(0, 6);
      mem[4] = xfer_w(8'h31, 8'h88);
      mem[5] = 16'hFFFF;
      wait_pos(8, 100);
      set_mode(2);
      push_w(padv(issue_pos, 2), 8'h30, 8'h77, "R9 resume");
      push_w(pos_of(6, 2), 8'h31, 8'h88, "R9 R4");
      wait_pos(7, 0);
      check(sb.size() == 0, "R9 resume writes", sb.size(), 0);
      check(pc_o == 10'd5, "R9 R12 held after resume", int'(pc_o), 5);

      // full-length list across the wrap
      set_mode(0);
      for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
      mem[0]    = xfer_w(8'h50, 8'h01);
      mem[1022] = xfer_w(8'h40, 8'hAA);
      wait_pos(3, 10);
      set_mode(1);
      push_w(padv(issue_pos, 2),    8'h50, 8'h01, "R8 restart from zero");
      push_w(padv(issue_pos, 1025), 8'h40, 8'hAA, "R6 end of list");
      push_w(padv(issue_pos, 1028), 8'h50, 8'h01, "R6 wrap to zero");
      repeat (1498) @(negedge clk);
      set_mode(0);
      repeat (1200) @(negedge clk);
      check(sb.size() == 0, "R6 wrap writes", sb.size(), 0);
      check(n_wr == 12, "R7 total write count", n_wr, 12);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule